// File: doc/BRIEF.md
# RTC Periodic and Alarm Interrupt Controller

This block sits beside the timekeeping counters of a real-time clock and turns their events into interrupt status. Once per tick it looks at two things. The first is the vector of pending periodic flags, masked by a periodic enable mask. The second is the set of current time fields, compared with a set of compare registers. A hit in either group sets a sticky status bit.

Any status set also raises a master interrupt bit. The master bit drives a single active-low interrupt pin. The host removes status bits one by one with write-one-to-clear requests. The pin goes high again only when the master bit itself is cleared.

Between ticks the status holds its value, except for host clears. If a set and a clear of the same bit land in the same cycle, the set wins. Bus decoding and the time counters themselves lie outside the block.

Top module: `rtcIrqTop`

## Requirements
- R1: After reset the periodic, alarm and master status bits are 0 and `irqN` is 1.
- R2: On a cycle with `tick` high, the periodic status bit is set if `perFlags & perEnable` is nonzero. Only bits 5:0 take part in this test. Bits 7:6 are storage-only and never cause a set.
- R3: The alarm status bit is never set while `cmpEnable` is all zero, even when fields match.
- R4: On a `tick` cycle with `cmpEnable` nonzero, the alarm status bit is set if any single field of `timeFields` equals the same field of `cmpFields`. Each field is 8 bits wide, and field k occupies bits 8k+7:8k. The fields in order 0 to 5 are seconds, minutes, hours, day, month and day of week.
- R5: The master bit is set in the same cycle as any status set. `irqN` falls when the master bit goes from 0 to 1, and rises when the master bit is cleared.
- R6: `clrMask` is write-one-to-clear and acts on any cycle, tick or not. Bit 0 clears the periodic bit, bit 1 clears the alarm bit and bit 2 clears the master bit.
- R7: When a set and a clear hit the same status bit in one cycle, the bit ends up set.
- R8: With `tick` low, no status bit is set, whatever the flags and compares show.
- R9: Clearing the periodic or alarm bit leaves the master bit and `irqN` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Evaluation enable, one cycle per time step |
| perFlags | input | 8 | Pending periodic flags |
| perEnable | input | 8 | Periodic enable mask |
| cmpEnable | input | 3 | Compare enable bits |
| timeFields | input | 48 | Current time fields, 6 x 8 bits |
| cmpFields | input | 48 | Compare registers, 6 x 8 bits |
| clrMask | input | 3 | Write-one-to-clear request {master, alarm, periodic} |
| perStatus | output | 1 | Periodic status bit |
| almStatus | output | 1 | Alarm status bit |
| mstStatus | output | 1 | Master interrupt status bit |
| irqN | output | 1 | Active-low interrupt pin |

## Verification
Tick evaluation and a host clear can both land on the same status bit in one cycle. The bench provokes this by raising `tick` while the compare fields match and asserting the alarm clear in the same cycle. It then expects the alarm bit still set one edge later. A clear of the master bit alone, given while the status bits remain set, shows in turn that a status bit left set does not bring the master bit back without a new tick.

// File: rtl/rtcIrqPkg.sv
package rtcIrqPkg;
  typedef struct packed {
    logic perSet;
    logic almSet;
    logic perClr;
    logic almClr;
    logic mstClr;
  } irqStrobeT;
endpackage

// File: rtl/rtcIrqCtrl.sv
module rtcIrqCtrl
  import rtcIrqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       perHit,
  input  logic       almHit,
  input  logic [2:0] clrMask,
  output irqStrobeT  strobes
);
  localparam int CLR_PER = 0;
  localparam int CLR_ALM = 1;
  localparam int CLR_MST = 2;

  always_comb begin
    strobes.perSet = tick & perHit;
    strobes.almSet = tick & almHit;
    strobes.perClr = clrMask[CLR_PER];
    strobes.almClr = clrMask[CLR_ALM];
    strobes.mstClr = clrMask[CLR_MST];
  end

  // R8: no set strobe leaves the control off a tick
  p_no_set_off_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |-> !(strobes.perSet || strobes.almSet));
endmodule

// File: rtl/rtcIrqDatapath.sv
module rtcIrqDatapath
  import rtcIrqPkg::*;
#(
  parameter int          PER_W      = 8,
  parameter logic [7:0]  PER_VALID  = 8'h3F,
  parameter int          FIELD_W    = 8,
  parameter int          NUM_FIELDS = 6,
  parameter int          CEN_W      = 3,
  localparam int         VEC_W      = FIELD_W * NUM_FIELDS
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PER_W-1:0] perFlags,
  input  logic [PER_W-1:0] perEnable,
  input  logic [CEN_W-1:0] cmpEnable,
  input  logic [VEC_W-1:0] timeFields,
  input  logic [VEC_W-1:0] cmpFields,
  input  irqStrobeT        strobes,
  output logic             perHit,
  output logic             almHit,
  output logic             perStatus,
  output logic             almStatus,
  output logic             mstStatus,
  output logic             irqN
);
  logic [NUM_FIELDS-1:0] fieldEq;
  logic [PER_W-1:0]      validMask;
  logic                  perNext, almNext, mstNext;

  assign validMask = PER_W'(PER_VALID);

  generate
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : gFieldCmp
      assign fieldEq[k] = timeFields[k*FIELD_W +: FIELD_W] == cmpFields[k*FIELD_W +: FIELD_W];
    end
  endgenerate

  assign perHit = |(perFlags & perEnable & validMask);
  assign almHit = (|cmpEnable) & (|fieldEq);

  always_comb begin
    perNext = strobes.perSet | (perStatus & ~strobes.perClr);
    almNext = strobes.almSet | (almStatus & ~strobes.almClr);
    mstNext = strobes.perSet | strobes.almSet | (mstStatus & ~strobes.mstClr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perStatus <= 1'b0;
      almStatus <= 1'b0;
      mstStatus <= 1'b0;
      irqN      <= 1'b1;
    end else begin
      perStatus <= perNext;
      almStatus <= almNext;
      mstStatus <= mstNext;
      irqN      <= ~mstNext;
    end
  end

  p_per_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.perSet |=> perStatus);
  p_alarm_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    almHit |-> (cmpEnable != '0));
  p_pin_falls_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mstStatus) |-> $fell(irqN));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.almSet && strobes.almClr) |=> almStatus);
  p_master_only_by_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mstStatus) |-> $past(strobes.mstClr));
endmodule

// File: rtl/rtcIrqTop.sv
module rtcIrqTop
  import rtcIrqPkg::*;
#(
  parameter int PER_W      = 8,
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 6,
  parameter int CEN_W      = 3,
  localparam int VEC_W     = FIELD_W * NUM_FIELDS
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [PER_W-1:0] perFlags,
  input  logic [PER_W-1:0] perEnable,
  input  logic [CEN_W-1:0] cmpEnable,
  input  logic [VEC_W-1:0] timeFields,
  input  logic [VEC_W-1:0] cmpFields,
  input  logic [2:0]       clrMask,
  output logic             perStatus,
  output logic             almStatus,
  output logic             mstStatus,
  output logic             irqN
);
  irqStrobeT strobes;
  logic      perHit, almHit;

  rtcIrqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .perHit(perHit), .almHit(almHit),
    .clrMask(clrMask), .strobes(strobes)
  );

  rtcIrqDatapath #(
    .PER_W(PER_W), .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .CEN_W(CEN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .perFlags(perFlags), .perEnable(perEnable),
    .cmpEnable(cmpEnable), .timeFields(timeFields), .cmpFields(cmpFields),
    .strobes(strobes), .perHit(perHit), .almHit(almHit),
    .perStatus(perStatus), .almStatus(almStatus), .mstStatus(mstStatus), .irqN(irqN)
  );
endmodule

// File: tb/tb_rtcIrqTop.sv
module tb_rtcIrqTop;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  perFlags = '0, perEnable = '0;
  logic [2:0]  cmpEnable = '0;
  logic [47:0] timeFields = '0, cmpFields = '0;
  logic [2:0]  clrMask = '0;
  logic        perStatus, almStatus, mstStatus, irqN;

  int checks = 0;
  int errors = 0;
  logic mPer = 0, mAlm = 0, mMst = 0;
  logic [3:0] expQ[$];
  string      tagQ[$];
  bit         done = 0;

  rtcIrqTop dut (
    .clk(clk), .rstN(rstN), .tick(tick), .perFlags(perFlags), .perEnable(perEnable),
    .cmpEnable(cmpEnable), .timeFields(timeFields), .cmpFields(cmpFields),
    .clrMask(clrMask), .perStatus(perStatus), .almStatus(almStatus),
    .mstStatus(mstStatus), .irqN(irqN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic anyFieldEq(input logic [47:0] a, input logic [47:0] b);
    for (int k = 0; k < 6; k++)
      if (a[k*8 +: 8] == b[k*8 +: 8]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic tk, input logic [7:0] fl, input logic [7:0] en,
                      input logic [2:0] ce, input logic [47:0] tv, input logic [47:0] cv,
                      input logic [2:0] clr, input string tag);
    logic ps, as;
    @(negedge clk);
    tick = tk; perFlags = fl; perEnable = en; cmpEnable = ce;
    timeFields = tv; cmpFields = cv; clrMask = clr;
    ps = tk && ((fl & en & 8'h3F) != 0);
    as = tk && (ce != 0) && anyFieldEq(tv, cv);
    mPer = ps | (mPer & ~clr[0]);
    mAlm = as | (mAlm & ~clr[1]);
    mMst = ps | as | (mMst & ~clr[2]);
    @(posedge clk);
    expQ.push_back({mPer, mAlm, mMst, ~mMst});
    tagQ.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [3:0] e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = {perStatus, almStatus, mstStatus, irqN};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: {per,alm,mst,irqN} actual %b expected %b", t, a, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] tv, noMatch, dowMatch, minMatch;
    tv       = 48'h03_07_15_10_22_45;
    noMatch  = 48'h00_00_00_00_00_00;
    dowMatch = 48'h03_00_00_00_00_00;
    minMatch = 48'h00_00_00_00_22_00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expQ.push_back(4'b0001); tagQ.push_back("R1 reset state");
    @(negedge clk);
    rstN = 1'b1;
    step(1, 8'h04, 8'h0C, 0, tv, noMatch, 0, "R2/R5 periodic set raises master and pin");
    step(0, 0, 0, 0, tv, noMatch, 3'b001, "R6/R9 periodic clear keeps master");
    step(0, 0, 0, 0, tv, noMatch, 3'b100, "R5/R6 master clear releases pin");
    step(1, 8'hC0, 8'hC0, 0, tv, noMatch, 0, "R2 storage-only bits ignored");
    step(1, 8'hFF, 8'h00, 0, tv, noMatch, 0, "R2 zero enable no set");
    step(1, 0, 0, 3'b000, tv, tv, 0, "R3 alarm gated by compare enable");
    step(1, 0, 0, 3'b010, tv, dowMatch, 0, "R4 day-of-week match sets alarm");
    step(0, 8'h01, 8'h01, 3'b001, tv, tv, 0, "R8 no tick no set");
    step(1, 0, 0, 3'b100, tv, tv, 3'b010, "R7 set wins over clear");
    step(0, 0, 0, 0, tv, noMatch, 3'b010, "R9 alarm clear keeps master");
    step(0, 0, 0, 0, tv, noMatch, 3'b100, "R6 master clear");
    step(1, 0, 0, 3'b001, tv, minMatch, 0, "R4 minutes match sets alarm");
    step(0, 0, 0, 0, tv, noMatch, 3'b100, "R9 master clear while alarm held");
    step(0, 8'h01, 8'h01, 3'b001, tv, tv, 0, "R8 held alarm does not re-raise master");
    step(1, 8'h20, 8'h20, 3'b001, tv, noMatch, 3'b111, "R7 periodic set beats clear-all");
    step(1, 0, 0, 3'b111, tv, noMatch, 3'b111, "R4 no field match clears all");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule